// File: doc/BRIEF.md
# Multiplier-Free Two-Band Wavelet Filter

This block performs a single level of a one-dimensional orthogonal wavelet analysis on a row of signed samples. For every two samples it produces one approximation (low-band) word and one detail (high-band) word. It uses no multipliers. The block keeps a sliding window of four samples and feeds the window into the datapath one bit position at a time, starting from the most significant bit. The bits that share a position across the window form an address. That address selects a precomputed sum of filter coefficients from a small table. A shift-and-add accumulator then rebuilds the full dot product.

Samples enter on a valid/ready stream. The upstream side marks the final sample of each row with `row_last`. At the end of the row the block treats the row as periodic: the first samples of the row are reused to finish the last window. The row therefore yields exactly half as many result pairs as it has samples. A `TAPS` parameter switches the block to a six-tap filter. In that mode it uses six-bit table addresses and six-sample windows.

Top module: `dawt_filter_pair`

## Requirements
- R1: A synchronous active-high `rst` forces `out_valid` low and `in_ready` high on the next cycle, and discards any partially received row and any evaluation in progress; no result from before the reset ever appears afterwards.
- R2: The low-band result of pair k of a row s[0..N-1] equals floor((31*s[2k] + 54*s[2k+1] + 14*s[2k+2] - 8*s[2k+3] + 32) / 64), a signed 10-bit value on `out_data` with `out_high` = 0 (coefficients in signed Q1.6).
- R3: The high-band result of pair k equals floor((-8*s[2k] - 14*s[2k+1] + 54*s[2k+2] - 31*s[2k+3] + 32) / 64), presented with `out_high` = 1.
- R4: Each pair is emitted low-band first, then high-band. The first pair of a row follows the fourth accepted sample, and each further pair follows every second accepted sample.
- R5: Sample indices at or beyond N wrap to index modulo N. After the sample flagged with `row_last`, the block emits the remaining pair by itself using s[N-2], s[N-1], s[0], s[1], so that an N-sample row (N even, N >= 4) gives exactly N/2 pairs.
- R6: `in_ready` is low from the cycle after the window-completing sample is accepted until the final result of that pair (including any wrap pair) has been produced. It is always low while a low-band result is being presented.
- R7: The low-band result is valid exactly 8 cycles (the sample width) after the clock edge that accepts the window-completing sample, and the high-band result is valid exactly 8 cycles after the low-band one; each is valid for one cycle.
- R8: Inputs of full magnitude (all 127, all -128, alternating 127/-128) give the exact results of R2 and R3 without wrap-around in the 18-bit accumulator or the 10-bit output.
- R9: A new row starting after `row_last` uses only its own samples; neither the window contents nor the wrap samples of the previous row leak into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | IN_W | Signed two's-complement input sample |
| row_last | input | 1 | Marks the final sample of a row |
| out_valid | output | 1 | One-cycle strobe for a result word |
| out_high | output | 1 | 0 for low-band result, 1 for high-band result |
| out_data | output | IN_W+2 | Signed rounded result word |

## Verification
A wrong window or wrap-register state changes the values of the very next pair. At the ports this shows up within about sixteen cycles of the sample that completes the window, as a mismatch against the arithmetic dot product. An error in the bit-plane counter or the table-select state moves the output strobes off their fixed eight-cycle spacing, or swaps the band tag. The bench catches both through exact timing checks and tag checks. An impulse sweep at every window position and polarity visits each coefficient through each table path. A fault in a single table entry therefore appears as a wrong value on an otherwise simple row.

// File: rtl/dawt_pkg.sv
package dawt_pkg;

    localparam int COEF_W = 8;   // table word width
    localparam int FRAC   = 6;   // fractional bits of the coefficients

    typedef enum logic { ST_FILL = 1'b0, ST_EVAL = 1'b1 } dawt_st_e;

    // low-band coefficients, signed Q1.6
    function automatic int lo_coef(int taps, int k);
        if (taps == 6) begin
            case (k)
                0: return 21;
                1: return 52;
                2: return 29;
                3: return -9;
                4: return -5;
                default: return 2;
            endcase
        end
        case (k)
            0: return 31;
            1: return 54;
            2: return 14;
            default: return -8;
        endcase
    endfunction

    // high-band coefficients: reversed low-band with alternating sign
    function automatic int hi_coef(int taps, int k);
        int m;
        m = lo_coef(taps, taps - 1 - k);
        return (k % 2 == 0) ? m : -m;
    endfunction

    // table entry: sum of the coefficients whose address bit is set
    function automatic int entry_sum(int taps, bit high, int addr);
        int s;
        s = 0;
        for (int i = 0; i < taps; i++) begin
            if (((addr >> i) & 1) == 1)
                s += high ? hi_coef(taps, i) : lo_coef(taps, i);
        end
        return s;
    endfunction

    function automatic int abs_coef_sum(int taps);
        int s;
        s = 0;
        for (int i = 0; i < taps; i++)
            s += (lo_coef(taps, i) < 0) ? -lo_coef(taps, i) : lo_coef(taps, i);
        return s;
    endfunction

endpackage

// File: rtl/dawt_coef_rom.sv
module dawt_coef_rom
    import dawt_pkg::*;
#(
    parameter int TAPS = 4,
    parameter bit HIGH = 1'b0
) (
    input  logic [TAPS-1:0]          addr,
    output logic signed [COEF_W-1:0] word
);
    localparam int DEPTH = 1 << TAPS;

    logic signed [COEF_W-1:0] tbl [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        localparam int VAL = entry_sum(TAPS, HIGH, a);
        assign tbl[a] = COEF_W'(VAL);
    end

    assign word = tbl[addr];

endmodule

// File: rtl/dawt_scale_acc.sv
module dawt_scale_acc
    import dawt_pkg::*;
#(
    parameter int ACC_W = 18,
    parameter int OUT_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic                     msb,
    input  logic                     lsb,
    input  logic                     tag_high,
    input  logic signed [COEF_W-1:0] lut,
    output logic                     res_valid,
    output logic                     res_high,
    output logic signed [OUT_W-1:0]  res_data
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    vld;
        logic                    hi;
        logic signed [OUT_W-1:0] res;
    } acc_s;

    acc_s cur_q, nxt_d;
    logic signed [ACC_W-1:0] term, base, sum, rnd;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        term = {{(ACC_W-COEF_W){lut[COEF_W-1]}}, lut};
        if (msb) term = -term;            // sign bit-plane carries negative weight
        base = msb ? '0 : (cur_q.acc <<< 1);
        sum  = base + term;
        rnd  = (sum + HALF) >>> FRAC;
        if (step) begin
            nxt_d.acc = sum;
            if (lsb) begin
                nxt_d.vld = 1'b1;
                nxt_d.hi  = tag_high;
                nxt_d.res = OUT_W'(rnd);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign res_valid = cur_q.vld;
    assign res_high  = cur_q.hi;
    assign res_data  = cur_q.res;

endmodule

// File: rtl/dawt_filter_pair.sv
module dawt_filter_pair
    import dawt_pkg::*;
#(
    parameter int IN_W = 8,
    parameter int TAPS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [IN_W-1:0]        in_data,
    input  logic                   row_last,
    output logic                   out_valid,
    output logic                   out_high,
    output logic signed [IN_W+1:0] out_data
);
    localparam int OUT_W  = IN_W + 2;
    localparam int ACC_W  = IN_W + 10;
    localparam int HEAD_N = TAPS - 2;
    localparam int BIT_W  = $clog2(IN_W);
    localparam int FILL_W = $clog2(TAPS + 1);
    localparam int WIX_W  = $clog2(HEAD_N + 1);

    typedef struct packed {
        dawt_st_e                       st;
        logic [TAPS-1:0][IN_W-1:0]      win;
        logic [HEAD_N-1:0][IN_W-1:0]    head;
        logic [FILL_W-1:0]              fill;
        logic                           odd;
        logic                           wrap;
        logic [WIX_W-1:0]               wix;
        logic [BIT_W-1:0]               bitp;
        logic                           sel;    // 1: low-band table, 0: high-band table
    } ctl_s;

    ctl_s cur_q, nxt_d;

    logic [TAPS-1:0]          plane;
    logic signed [COEF_W-1:0] lo_word, hi_word, lut_word;
    logic                     step, msb, lsb;

    always_comb begin
        for (int i = 0; i < TAPS; i++) plane[i] = cur_q.win[i][cur_q.bitp];
    end

    dawt_coef_rom #(.TAPS(TAPS), .HIGH(1'b0)) lo_rom_i (.addr(plane), .word(lo_word));
    dawt_coef_rom #(.TAPS(TAPS), .HIGH(1'b1)) hi_rom_i (.addr(plane), .word(hi_word));

    assign lut_word = cur_q.sel ? lo_word : hi_word;
    assign step     = (cur_q.st == ST_EVAL);
    assign msb      = (cur_q.bitp == BIT_W'(IN_W - 1));
    assign lsb      = (cur_q.bitp == '0);
    assign in_ready = (cur_q.st == ST_FILL);

    always_comb begin
        logic             fire;
        logic [FILL_W-1:0] fill_n;
        nxt_d  = cur_q;
        fire   = 1'b0;
        fill_n = cur_q.fill;
        if (cur_q.st == ST_FILL) begin
            if (in_valid) begin
                for (int i = 0; i < TAPS - 1; i++) nxt_d.win[i] = cur_q.win[i+1];
                nxt_d.win[TAPS-1] = in_data;
                for (int j = 0; j < HEAD_N; j++)
                    if (cur_q.fill == FILL_W'(j)) nxt_d.head[j] = in_data;
                if (cur_q.fill < FILL_W'(TAPS)) fill_n = cur_q.fill + 1'b1;
                fire       = (fill_n == FILL_W'(TAPS)) && cur_q.odd;
                nxt_d.fill = fill_n;
                nxt_d.odd  = ~cur_q.odd;
                if (row_last) begin
                    nxt_d.fill = '0;
                    nxt_d.odd  = 1'b0;
                end
                if (fire) begin
                    nxt_d.st   = ST_EVAL;
                    nxt_d.bitp = BIT_W'(IN_W - 1);
                    nxt_d.sel  = 1'b1;
                    nxt_d.wrap = row_last;
                    nxt_d.wix  = '0;
                end
            end
        end else begin
            if (!lsb) begin
                nxt_d.bitp = cur_q.bitp - 1'b1;
            end else begin
                nxt_d.bitp = BIT_W'(IN_W - 1);
                if (cur_q.sel) begin
                    nxt_d.sel = 1'b0;
                end else begin
                    nxt_d.sel = 1'b1;
                    if (cur_q.wrap && cur_q.wix < WIX_W'(HEAD_N)) begin
                        for (int i = 0; i < TAPS - 2; i++) nxt_d.win[i] = cur_q.win[i+2];
                        for (int j = 0; j < HEAD_N; j += 2) begin
                            if (cur_q.wix == WIX_W'(j)) begin
                                nxt_d.win[TAPS-2] = cur_q.head[j];
                                nxt_d.win[TAPS-1] = cur_q.head[j+1];
                            end
                        end
                        nxt_d.wix = cur_q.wix + WIX_W'(2);
                    end else begin
                        nxt_d.st   = ST_FILL;
                        nxt_d.wrap = 1'b0;
                        nxt_d.wix  = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    dawt_scale_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W)) acc_i (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .msb      (msb),
        .lsb      (lsb),
        .tag_high (~cur_q.sel),
        .lut      (lut_word),
        .res_valid(out_valid),
        .res_high (out_high),
        .res_data (out_data)
    );

endmodule

// File: rtl/dawt_filter_pair_chk.sv
module dawt_filter_pair_chk
    import dawt_pkg::*;
#(
    parameter int IN_W = 8,
    parameter int TAPS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_high,
    input logic signed [IN_W+1:0] out_data
);
    localparam int MAX_MAG = (abs_coef_sum(TAPS) * (1 << (IN_W - 1)) + 32) / 64 + 1;

    logic        hi_pend_q;
    logic [15:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_pend_q <= 1'b0;
            gap_q     <= '0;
        end else if (out_valid && !out_high) begin
            hi_pend_q <= 1'b1;
            gap_q     <= '0;
        end else if (out_valid && out_high) begin
            hi_pend_q <= 1'b0;
            gap_q     <= '0;
        end else if (hi_pend_q) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_high) |-> (hi_pend_q && gap_q == 16'(IN_W - 1))); // R7

    AST_LOW_NOT_DOUBLED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_high) |-> !hi_pend_q); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_high) |-> !in_ready); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_data) <= MAX_MAG && $signed(out_data) >= -MAX_MAG)); // R8

endmodule

bind dawt_filter_pair dawt_filter_pair_chk #(.IN_W(IN_W), .TAPS(TAPS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_high (out_high),
    .out_data (out_data)
);

// File: tb/dawt_filter_pair_tb_top.sv
module dawt_filter_pair_tb_top;
    localparam int IN_W  = 8;
    localparam int OUT_W = IN_W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic row_last = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic in_ready, out_valid, out_high;
    logic signed [OUT_W-1:0] out_data;

    always #5 clk = ~clk;

    dawt_filter_pair #(.IN_W(IN_W), .TAPS(4)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .row_last(row_last), .out_valid(out_valid),
        .out_high(out_high), .out_data(out_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int row   [0:15];
    int exp_v [0:15];
    bit exp_h [0:15];
    string exp_r [0:15];
    int exp_n = 0;
    int mon_idx = 0;
    string extra_tag = "R5";
    int HC [4] = '{31, 54, 14, -8};
    int GC [4] = '{-8, -14, 54, -31};

    task automatic check(bit ok, string tag, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_tests++;
            if (mon_idx >= exp_n) begin
                n_fail++;
                $display("FAIL %s: unexpected result %0d, expected none", extra_tag, out_data);
            end else if (out_high != exp_h[mon_idx]) begin
                n_fail++;
                $display("FAIL R4: band tag %0d expected %0d at result %0d",
                         out_high, exp_h[mon_idx], mon_idx);
            end else if (int'(out_data) != exp_v[mon_idx]) begin
                n_fail++;
                $display("FAIL %s: result %0d actual %0d expected %0d",
                         exp_r[mon_idx], mon_idx, out_data, exp_v[mon_idx]);
            end
            mon_idx++;
        end
    end

    task automatic build(int n, string tag);
        exp_n   = n;
        mon_idx = 0;
        for (int k = 0; k < n / 2; k++) begin
            int lo = 0;
            int hi = 0;
            for (int i = 0; i < 4; i++) begin
                lo += HC[i] * row[(2*k + i) % n];
                hi += GC[i] * row[(2*k + i) % n];
            end
            exp_v[2*k]   = (lo + 32) >>> 6;
            exp_h[2*k]   = 1'b0;
            exp_r[2*k]   = (k == n/2 - 1) ? "R5" : ((tag == "") ? "R2" : tag);
            exp_v[2*k+1] = (hi + 32) >>> 6;
            exp_h[2*k+1] = 1'b1;
            exp_r[2*k+1] = (k == n/2 - 1) ? "R5" : ((tag == "") ? "R3" : tag);
        end
    endtask

    task automatic send(int v, bit last);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = IN_W'(v);
        row_last = last;
        @(negedge clk);
        in_valid = 1'b0;
        row_last = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int t = 0;
        while (mon_idx < exp_n && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);
        check(mon_idx == exp_n, tag, mon_idx, exp_n);
    endtask

    task automatic run_row(int n, string tag, string cnt_tag);
        build(n, tag);
        for (int i = 0; i < n; i++) send(row[i], i == n - 1);
        wait_done(cnt_tag);
    endtask

    initial begin
        int quiet;
        int vals [4] = '{-128, -1, 1, 127};

        // reset state (R1)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(in_ready, "R1 in_ready after reset", in_ready, 1);

        // exact latency, ready drop, periodic wrap (R6, R7, R5)
        for (int i = 0; i < 4; i++) row[i] = 10 * i - 17;
        build(4, "");
        for (int i = 0; i < 3; i++) send(row[i], 1'b0);
        send(row[3], 1'b1);
        check(!in_ready, "R6 in_ready after window fill", in_ready, 0);
        quiet = 0;
        repeat (7) begin @(negedge clk); quiet += out_valid; end
        check(quiet == 0, "R7 early low result", quiet, 0);
        @(negedge clk);
        check(out_valid && !out_high, "R7 low result at 8 cycles", {out_valid, out_high}, 2);
        check(!in_ready, "R6 in_ready during evaluation", in_ready, 0);
        quiet = 0;
        repeat (7) begin @(negedge clk); quiet += out_valid; end
        check(quiet == 0, "R7 early high result", quiet, 0);
        @(negedge clk);
        check(out_valid && out_high, "R7 high result 8 cycles after low", {out_valid, out_high}, 3);
        wait_done("R5 pair count");

        // impulse sweep over every window position and polarity (R2, R3)
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 4; v++) begin
                for (int i = 0; i < 4; i++) row[i] = (i == p) ? vals[v] : 0;
                run_row(4, "", "R5 impulse pair count");
            end
        end

        // varied patterns and lengths (R2, R3, R5, R9)
        for (int i = 0; i < 16; i++) row[i] = 9 * i - 60;
        run_row(8, "", "R9 ramp row 8");
        for (int i = 0; i < 16; i++) row[i] = ((i * 37 + 11) % 256) - 128;
        run_row(16, "", "R9 pseudo row 16");
        for (int i = 0; i < 16; i++) row[i] = ((i * 73 + 5) % 256) - 128;
        run_row(4, "R9", "R9 short row after long");

        // extreme magnitudes (R8)
        for (int i = 0; i < 16; i++) row[i] = 127;
        run_row(8, "R8", "R8 positive row");
        for (int i = 0; i < 16; i++) row[i] = -128;
        run_row(8, "R8", "R8 negative row");
        for (int i = 0; i < 16; i++) row[i] = (i % 2 == 0) ? 127 : -128;
        run_row(16, "R8", "R8 alternating row");
        for (int i = 0; i < 16; i++) row[i] = (i % 2 == 0) ? -128 : 127;
        run_row(6, "R8", "R8 alternating row 6");

        // reset discards a partial row (R1)
        extra_tag = "R1";
        exp_n = 0; mon_idx = 0;
        for (int i = 0; i < 3; i++) send(99 - 40 * i, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) row[i] = 5 - 3 * i;
        run_row(4, "R1", "R1 row after partial reset");

        // reset during evaluation (R1)
        exp_n = 0; mon_idx = 0;
        for (int i = 0; i < 4; i++) send(70 - 30 * i, i == 3);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        repeat (40) @(negedge clk);
        check(in_ready, "R1 ready after mid-evaluation reset", in_ready, 1);
        check(mon_idx == 0, "R1 no result after mid-evaluation reset", mon_idx, 0);
        for (int i = 0; i < 8; i++) row[i] = 3 * i * i - 50;
        run_row(8, "R1", "R1 row after mid-evaluation reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule